// File: doc/BRIEF.md
# MSB-First Sequential Unsigned Multiplier

This block multiplies two unsigned operands with one adder and one multiplier bit per clock. It scans the multiplier from its most significant bit down. The multiplicand sits in a register that never shifts. Each working cycle, the running product doubles and then takes in the multiplicand or zero, as the current top bit of the multiplier selects. A multiply of a B_W-bit multiplier takes exactly B_W working cycles. In the default 8x8 configuration this gives a 16-bit result after eight clocks.

A one-cycle `start` pulse, given while the block is idle, latches both operands and clears the product. It also raises `busy`. `busy` falls once the last multiplier bit has been accumulated, and `product` then holds the full result until the next accepted start. In the cycle after an accepted start, the block also puts out a one-cycle flag update for the surrounding status logic. That update clears the negative, sign and overflow flags and sets a multiply-in-progress indicator.

Top module: `horner_mul`

## Requirements
- R1: On a clock edge where `start` is 1 and `busy` is 0, the block latches `op_a` and `op_b`, clears `product` to zero and raises `busy`.
- R2: After an accepted start, `busy` stays high for exactly B_W clock cycles (8 by default) and then falls.
- R3: When `busy` falls, `product` equals the unsigned product `op_a * op_b` of the latched operands, A_W+B_W bits wide (16 by default), with no truncation, including the case 0xFF*0xFF = 0xFE01.
- R4: The multiplier is scanned from its most significant bit first. After k working cycles (k = 0..B_W), `product` equals `op_a * (op_b >> (B_W-k))`.
- R5: In the cycle after an accepted start, `flag_we` is 1 for exactly one cycle, with `flag_neg`, `flag_sign` and `flag_ovf` equal to 0 and `flag_mul` equal to 1. `flag_we` is 0 in every other cycle.
- R6: A `start` pulse while `busy` is 1 is ignored. The running multiply finishes with its original operands and its original cycle count, and no flag update follows that pulse.
- R7: Once `busy` has fallen, `product` holds its value until the next accepted start.
- R8: While `rst_n` is low, `busy`, `product`, `flag_we` and all four flag outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle request to begin a multiply |
| op_a | input | A_W (8) | Multiplicand |
| op_b | input | B_W (8) | Multiplier |
| busy | output | 1 | High while the multiply runs |
| product | output | A_W+B_W (16) | Running and final product |
| flag_we | output | 1 | One-cycle strobe for the status flag update |
| flag_neg | output | 1 | Negative flag value (cleared by a multiply) |
| flag_sign | output | 1 | Sign flag value (cleared by a multiply) |
| flag_ovf | output | 1 | Overflow flag value (cleared by a multiply) |
| flag_mul | output | 1 | Multiply indicator flag value (set by a multiply) |

## Verification
Every multiplicand is run against a fixed set of multiplier patterns, and every multiplier against a fixed set of multiplicands. These include zero, one, all ones and alternating bits. The product is compared after every working cycle against the MSB-first partial value. An LSB-first scan, or a shift of the wrong register, fails on the first intermediate cycle even when the final result is right. The busy span is counted on every run, so an off-by-one in the down counter shows up as seven or nine cycles. A start pulse in the middle of a 0xFF*0xFF run checks that a design which reloads its operands or restarts its counter gives a wrong result or a wrong span. A further check catches a design that issues a second flag update. After the run ends, the bench waits several idle cycles and checks that the product has not drifted.

// File: rtl/horner_mul_pkg.sv
package horner_mul_pkg;

  // Default operand widths for the multiplier core.
  localparam int unsigned DEF_A_W = 8;
  localparam int unsigned DEF_B_W = 8;

  // Status flag group written by the block when a multiply is accepted.
  typedef struct packed {
    logic neg;
    logic sign;
    logic ovf;
    logic mul;
  } mul_flags_t;

  localparam mul_flags_t FLAGS_ON_START = '{neg: 1'b0, sign: 1'b0, ovf: 1'b0, mul: 1'b1};
  localparam mul_flags_t FLAGS_RESET    = '{neg: 1'b0, sign: 1'b0, ovf: 1'b0, mul: 1'b0};

endpackage

// File: rtl/hm_seq_ctrl.sv
// Iteration control: accepts a start when idle, runs a down counter for
// B_W working cycles and drops busy on the clock after it reaches zero.
module hm_seq_ctrl #(
  parameter int unsigned B_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step,
  output logic busy
);

  localparam int unsigned CNT_W = (B_W > 1) ? $clog2(B_W) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(B_W - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);
  assign accept   = start & ~busy_q;
  assign step     = busy_q;
  assign busy     = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (busy_q) begin
      if (cnt_zero) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/hm_accum.sv
// Datapath: static multiplicand register, left-rotating multiplier
// register and a product that doubles and adds each working cycle.
module hm_accum #(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic [A_W-1:0]     a_in,
  input  logic [B_W-1:0]     b_in,
  output logic [A_W+B_W-1:0] prod
);

  localparam int unsigned P_W = A_W + B_W;

  logic [A_W-1:0] mcand_q;
  logic [B_W-1:0] mplier_q, mplier_d;
  logic [P_W-1:0] prod_q, prod_d;
  logic [A_W-1:0] addend;
  logic           top_bit;

  assign top_bit = mplier_q[B_W-1];

  // Multiplicand gated bit by bit with the current top multiplier bit.
  for (genvar i = 0; i < A_W; i++) begin : g_gate
    assign addend[i] = mcand_q[i] & top_bit;
  end

  always_comb begin
    mplier_d = mplier_q;
    prod_d   = prod_q;
    if (load) begin
      mplier_d = b_in;
      prod_d   = '0;
    end else if (step) begin
      mplier_d = {mplier_q[B_W-2:0], mplier_q[B_W-1]};
      prod_d   = {prod_q[P_W-2:0], 1'b0} + {{B_W{1'b0}}, addend};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
    end else if (load) begin
      mcand_q <= a_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mplier_q <= '0;
      prod_q   <= '0;
    end else begin
      mplier_q <= mplier_d;
      prod_q   <= prod_d;
    end
  end

  assign prod = prod_q;

endmodule

// File: rtl/hm_flag_unit.sv
// Produces a one-cycle flag update after each accepted start.
module hm_flag_unit
  import horner_mul_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  output logic       upd,
  output mul_flags_t flags
);

  logic       upd_q;
  mul_flags_t flags_q, flags_d;

  always_comb begin
    flags_d = flags_q;
    if (load) begin
      flags_d = FLAGS_ON_START;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_q   <= 1'b0;
      flags_q <= FLAGS_RESET;
    end else begin
      upd_q   <= load;
      flags_q <= flags_d;
    end
  end

  assign upd   = upd_q;
  assign flags = flags_q;

endmodule

// File: rtl/horner_mul.sv
module horner_mul
  import horner_mul_pkg::*;
#(
  parameter int unsigned A_W = DEF_A_W,
  parameter int unsigned B_W = DEF_B_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [A_W-1:0]     op_a,
  input  logic [B_W-1:0]     op_b,
  output logic               busy,
  output logic [A_W+B_W-1:0] product,
  output logic               flag_we,
  output logic               flag_neg,
  output logic               flag_sign,
  output logic               flag_ovf,
  output logic               flag_mul
);

  logic       accept;
  logic       step;
  mul_flags_t flags;

  hm_seq_ctrl #(.B_W(B_W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .step   (step),
    .busy   (busy)
  );

  hm_accum #(.A_W(A_W), .B_W(B_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .step  (step),
    .a_in  (op_a),
    .b_in  (op_b),
    .prod  (product)
  );

  hm_flag_unit u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept),
    .upd   (flag_we),
    .flags (flags)
  );

  assign flag_neg  = flags.neg;
  assign flag_sign = flags.sign;
  assign flag_ovf  = flags.ovf;
  assign flag_mul  = flags.mul;

endmodule

// File: rtl/horner_mul_chk.sv
module horner_mul_chk #(
  parameter int unsigned A_W = 8,
  parameter int unsigned B_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [A_W-1:0]     op_a,
  input logic [B_W-1:0]     op_b,
  input logic               busy,
  input logic [A_W+B_W-1:0] product,
  input logic               flag_we,
  input logic               flag_neg,
  input logic               flag_sign,
  input logic               flag_ovf,
  input logic               flag_mul
);

  localparam int unsigned P_W = A_W + B_W;

  logic [A_W-1:0] a_cap;
  logic [B_W-1:0] b_cap;
  logic [15:0]    span;
  logic           go;

  assign go = start & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_cap <= '0;
      b_cap <= '0;
      span  <= '0;
    end else if (go) begin
      a_cap <= op_a;
      b_cap <= op_b;
      span  <= '0;
    end else if (busy) begin
      span <= span + 1'b1;
    end
  end

  // R1
  a_r1_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (busy && product == '0));

  // R2
  a_r2_busy_span: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (span == 16'(B_W)));

  // R3
  a_r3_final_product: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (product == (P_W'(a_cap) * P_W'(b_cap))));

  // R5
  a_r5_flag_update: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (flag_we && !flag_neg && !flag_sign && !flag_ovf && flag_mul));

  // R6
  a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !flag_we);

  // R7
  a_r7_product_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));

endmodule

bind horner_mul horner_mul_chk #(.A_W(A_W), .B_W(B_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .op_a      (op_a),
  .op_b      (op_b),
  .busy      (busy),
  .product   (product),
  .flag_we   (flag_we),
  .flag_neg  (flag_neg),
  .flag_sign (flag_sign),
  .flag_ovf  (flag_ovf),
  .flag_mul  (flag_mul)
);

// File: tb/horner_mul_tb.sv
`timescale 1ns/1ps
module horner_mul_tb;

  localparam int A_W = 8;
  localparam int B_W = 8;
  localparam int P_W = A_W + B_W;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [A_W-1:0] op_a = '0;
  logic [B_W-1:0] op_b = '0;
  logic           busy;
  logic [P_W-1:0] product;
  logic           flag_we, flag_neg, flag_sign, flag_ovf, flag_mul;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  horner_mul #(.A_W(A_W), .B_W(B_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .product(product), .flag_we(flag_we), .flag_neg(flag_neg),
    .flag_sign(flag_sign), .flag_ovf(flag_ovf), .flag_mul(flag_mul)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [P_W-1:0] partial(input logic [A_W-1:0] a, input logic [B_W-1:0] b, input int k);
    logic [P_W-1:0] bb;
    bb = P_W'(b) >> (B_W - k);
    return P_W'(a) * bb;
  endfunction

  // One multiply; a busy-time start pulse is optionally injected at cycle inj.
  task automatic run_mul(input logic [A_W-1:0] a, input logic [B_W-1:0] b, input int inj);
    int n;
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 busy after start", busy, 1);
    check("R1 product cleared", product, 0);
    check("R5 flag_we", flag_we, 1);
    check("R5 flag values", {flag_neg, flag_sign, flag_ovf, flag_mul}, 4'b0001);
    n = 0;
    while (busy && n < 20) begin
      check("R4 msb-first partial", product, partial(a, b, n));
      if (n == inj) begin
        op_a = ~a; op_b = ~b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R6 no flag update on busy start", flag_we, 0);
      end else begin
        @(negedge clk);
        if (n == 0) check("R5 flag_we single cycle", flag_we, 0);
      end
      n++;
    end
    check("R2 busy span", n, B_W);
    check("R3 final product", product, P_W'(a) * P_W'(b));
  endtask

  initial begin
    int t;
    t = 0;
    while (!finished && t < 150000) begin
      @(posedge clk);
      t++;
    end
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] pats [8];
    logic [P_W-1:0] held;
    pats = '{8'h00, 8'h01, 8'hFF, 8'hAA, 8'h55, 8'h80, 8'h7F, 8'h96};
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 busy in reset", busy, 0);
    check("R8 product in reset", product, 0);
    check("R8 flags in reset", {flag_we, flag_neg, flag_sign, flag_ovf, flag_mul}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 idle after reset", busy, 0);

    run_mul(8'hFF, 8'hFF, -1);
    run_mul(8'h00, 8'h00, -1);
    run_mul(8'h01, 8'h01, -1);
    run_mul(8'hAA, 8'h55, -1);

    for (int a = 0; a < 256; a++)
      for (int p = 0; p < 8; p++) run_mul(8'(a), pats[p], -1);
    for (int b = 0; b < 256; b++)
      for (int p = 0; p < 8; p++) run_mul(pats[p], 8'(b), -1);

    // R6: start while busy, injected at several points
    run_mul(8'hFF, 8'hFF, 3);
    run_mul(8'h5A, 8'hC3, 0);
    run_mul(8'h81, 8'h81, 7);

    // R7: product holds through idle cycles
    run_mul(8'hD7, 8'hB9, -1);
    held = product;
    repeat (6) @(negedge clk);
    check("R7 product holds", product, held);
    check("R7 expected value", held, 16'(8'hD7) * 16'(8'hB9));
    check("R5 no stray flag update", flag_we, 0);

    // R8: reset mid-run
    @(negedge clk);
    op_a = 8'h33; op_b = 8'h44; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 async reset busy", busy, 0);
    check("R8 async reset product", product, 0);
    check("R8 async reset flags", {flag_we, flag_neg, flag_sign, flag_ovf, flag_mul}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_mul(8'h33, 8'h44, -1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule